// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps twelve 32-bit traffic statistics for an Ethernet MAC. Six counters track the transmit side, all driven by one end-of-frame strobe: octets and frames over all frames, octets and frames over good frames only, frames aborted by a transmit underflow, and frames with a carrier error. Retried transmit attempts are never counted. The other six track the receive side, driven by one receive end-of-frame strobe: frames, octets, multicast frames, CRC errors, length errors and FIFO overflows. The MAC supplies the byte counts without preamble.

Each counter records a status bit when its value crosses half of full scale. It records a second status bit when it reaches full scale. A per-counter mask bit keeps both of these bits off the interrupt output. The status bits stay set until the status register is read, and reading it clears them. A small register port reads and writes the counters, writes the mask, and reads the status. Read data appears one cycle after the read strobe.

Top module: `statsCounterBank`

## Requirements
- R1: After reset every counter, the mask register and the status register are zero, and `irq` is low.
- R2: Address map: addresses 0 to 11 select the counters in this order: tx octets (all), tx frames (all), tx octets (good), tx frames (good), tx underflow aborts, tx carrier errors, rx frames, rx octets, rx multicast, rx CRC errors, rx length errors, rx FIFO overflows. Address 12 is the mask register, with bit i belonging to counter i. Address 13 is the status register, with bit i for the half-scale event of counter i and bit 16+i for its full-scale event. Addresses 14 and 15 read zero. `regRdData` carries the value from before the edge at which `regRdEn` is sampled, and it is valid from that edge on.
- R3: A `txDone` without `txRetry` adds `txBytes` to tx octets (all) and adds 1 to tx frames (all). A `txDone` with `txRetry` changes no counter.
- R4: A counted transmit frame with `txGood` also adds `txBytes` to tx octets (good) and adds 1 to tx frames (good).
- R5: A counted transmit frame adds 1 to tx underflow aborts when `txUnderflow` is set, and adds 1 to tx carrier errors when `txCarrierErr` is set.
- R6: `rxDone` adds 1 to rx frames and adds `rxBytes` to rx octets. It also adds 1 to rx multicast, rx CRC errors, rx length errors and rx FIFO overflows for each of `rxMulticast`, `rxCrcErr`, `rxLenErr` and `rxFifoOvf` that is set.
- R7: An increment that moves a counter from below 0x8000_0000 to 0x8000_0000 or above sets the counter's half-scale status bit, even when a single octet add jumps past the threshold.
- R8: An increment that moves a counter from below 0xFFFF_FFFF to 0xFFFF_FFFF or beyond sets the counter's full-scale status bit.
- R9: A register write to a counter in the same cycle as an increment of that counter loads the written value, and the increment is dropped. A write never sets a status bit. Writes to the status register and to addresses 14 and 15 have no effect.
- R10: Counters wrap modulo 2^32. A frame increment at 0xFFFF_FFFF gives 0 and sets no status bit.
- R11: A read of the status register clears every bit it returned. A threshold event in the same cycle as that read stays set and is not part of the returned value.
- R12: A set mask bit keeps both status bits of its counter off `irq`, but the status bits are still recorded. Mask bits 12 to 31 read as zero and ignore writes.
- R13: `irq` is the OR of all unmasked status bits. It rises right after the clock edge at which the threshold event is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txDone | input | 1 | Transmit end-of-frame strobe |
| txRetry | input | 1 | Frame attempt will be retried (not counted) |
| txGood | input | 1 | Transmitted frame was good |
| txUnderflow | input | 1 | Frame aborted by transmit underflow |
| txCarrierErr | input | 1 | Carrier error during frame |
| txBytes | input | 16 | Transmitted byte count, preamble excluded |
| rxDone | input | 1 | Receive end-of-frame strobe |
| rxBytes | input | 16 | Received byte count |
| rxMulticast | input | 1 | Received frame was multicast |
| rxCrcErr | input | 1 | Received frame had a CRC error |
| rxLenErr | input | 1 | Received frame had a length error |
| rxFifoOvf | input | 1 | Received frame hit a FIFO overflow |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The threshold events are the hard part to reach. Frames alone would need about two billion of them to reach half scale. The stimulus therefore uses register writes to place counters just below 0x8000_0000 or 0xFFFF_FFFF. It then sends frames whose byte counts jump past a threshold in one add, send a counter to full scale, and then wrap it. Directed cycles also line up a counter write with an increment of the same counter, and a status read with a new threshold event. A seeded random phase mixes events, masks, near-threshold preloads and reads, all checked against a bench model.

// File: rtl/statsPkg.sv
package statsPkg;
  localparam int CNT_W    = 32;
  localparam int AMT_W    = 16;
  localparam int NUM_CNT  = 12;
  localparam int ADDR_W   = 4;
  localparam int FULL_OFS = 16;

  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_CNT);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CNT + 1);

  localparam int IX_TX_OCT_ALL  = 0;
  localparam int IX_TX_FRM_ALL  = 1;
  localparam int IX_TX_OCT_GOOD = 2;
  localparam int IX_TX_FRM_GOOD = 3;
  localparam int IX_TX_UNDERRUN = 4;
  localparam int IX_TX_CARRIER  = 5;
  localparam int IX_RX_FRM      = 6;
  localparam int IX_RX_OCT      = 7;
  localparam int IX_RX_MCAST    = 8;
  localparam int IX_RX_CRC      = 9;
  localparam int IX_RX_LEN      = 10;
  localparam int IX_RX_OVF      = 11;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_CNT-1:0]            wrEn;
    logic [NUM_CNT-1:0]            incEn;
    logic [NUM_CNT-1:0][AMT_W-1:0] incAmt;
    logic [CNT_W-1:0]              wrData;
  } strobe_t;
endpackage

// File: rtl/statsDatapath.sv
module statsDatapath
  import statsPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strb,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cntVal,
  output logic [NUM_CNT-1:0]              hitHalf,
  output logic [NUM_CNT-1:0]              hitFull
);
  localparam logic [CNT_W:0] FULL_SUM = {1'b0, {CNT_W{1'b1}}};
  localparam int PAD_W = CNT_W + 1 - AMT_W;

  logic [NUM_CNT-1:0][CNT_W:0] sumArr;
  logic [NUM_CNT-1:0]          active;

  // threshold detection on the widened sum so multi-step adds cross once
  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      active[i]  = strb.incEn[i] & ~strb.wrEn[i];
      sumArr[i]  = {1'b0, cntVal[i]} + {{PAD_W{1'b0}}, strb.incAmt[i]};
      hitHalf[i] = active[i] & ~cntVal[i][CNT_W-1] & sumArr[i][CNT_W-1];
      hitFull[i] = active[i] & (cntVal[i] != {CNT_W{1'b1}}) & (sumArr[i] >= FULL_SUM);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (strb.wrEn[i]) begin
          cntVal[i] <= strb.wrData;
        end else if (strb.incEn[i]) begin
          cntVal[i] <= sumArr[i][CNT_W-1:0];
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : gChk
      AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrEn[g] |=> cntVal[g] == $past(strb.wrData)); // R9
      AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rstN)
        (strb.incEn[g] && !strb.wrEn[g] && cntVal[g] == {CNT_W{1'b1}}
         && strb.incAmt[g] == AMT_W'(1)) |=> cntVal[g] == '0); // R10
    end
  endgenerate
endmodule

// File: rtl/statsCtrl.sv
module statsCtrl
  import statsPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          txDone,
  input  logic                          txRetry,
  input  logic                          txGood,
  input  logic                          txUnderflow,
  input  logic                          txCarrierErr,
  input  logic [AMT_W-1:0]              txBytes,
  input  logic                          rxDone,
  input  logic [AMT_W-1:0]              rxBytes,
  input  logic                          rxMulticast,
  input  logic                          rxCrcErr,
  input  logic                          rxLenErr,
  input  logic                          rxFifoOvf,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWrEn,
  input  logic                          regRdEn,
  input  logic [CNT_W-1:0]              regWrData,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input  logic [NUM_CNT-1:0]            hitHalf,
  input  logic [NUM_CNT-1:0]            hitFull,
  output strobe_t                       strb,
  output logic [CNT_W-1:0]              regRdData,
  output logic                          irq
);
  localparam logic [AMT_W-1:0] ONE = AMT_W'(1);

  logic [NUM_CNT-1:0] maskQ;
  logic [CNT_W-1:0]   statusQ;
  logic [CNT_W-1:0]   statSet;
  logic [CNT_W-1:0]   rdMux;
  logic               txCount;
  logic               rdStat;

  assign txCount = txDone & ~txRetry;
  assign rdStat  = regRdEn && (regAddr == STAT_ADDR);

  // event and write strobes
  always_comb begin
    strb        = '0;
    strb.wrData = regWrData;
    for (int i = 0; i < NUM_CNT; i++) begin
      strb.wrEn[i] = regWrEn && (regAddr == ADDR_W'(i));
    end
    strb.incEn[IX_TX_OCT_ALL]   = txCount;
    strb.incAmt[IX_TX_OCT_ALL]  = txBytes;
    strb.incEn[IX_TX_FRM_ALL]   = txCount;
    strb.incAmt[IX_TX_FRM_ALL]  = ONE;
    strb.incEn[IX_TX_OCT_GOOD]  = txCount & txGood;
    strb.incAmt[IX_TX_OCT_GOOD] = txBytes;
    strb.incEn[IX_TX_FRM_GOOD]  = txCount & txGood;
    strb.incAmt[IX_TX_FRM_GOOD] = ONE;
    strb.incEn[IX_TX_UNDERRUN]  = txCount & txUnderflow;
    strb.incAmt[IX_TX_UNDERRUN] = ONE;
    strb.incEn[IX_TX_CARRIER]   = txCount & txCarrierErr;
    strb.incAmt[IX_TX_CARRIER]  = ONE;
    strb.incEn[IX_RX_FRM]       = rxDone;
    strb.incAmt[IX_RX_FRM]      = ONE;
    strb.incEn[IX_RX_OCT]       = rxDone;
    strb.incAmt[IX_RX_OCT]      = rxBytes;
    strb.incEn[IX_RX_MCAST]     = rxDone & rxMulticast;
    strb.incAmt[IX_RX_MCAST]    = ONE;
    strb.incEn[IX_RX_CRC]       = rxDone & rxCrcErr;
    strb.incAmt[IX_RX_CRC]      = ONE;
    strb.incEn[IX_RX_LEN]       = rxDone & rxLenErr;
    strb.incAmt[IX_RX_LEN]      = ONE;
    strb.incEn[IX_RX_OVF]       = rxDone & rxFifoOvf;
    strb.incAmt[IX_RX_OVF]      = ONE;
  end

  // read mux
  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (regAddr == ADDR_W'(i)) rdMux = cntVal[i];
    end
    if (regAddr == MASK_ADDR) rdMux = {{(CNT_W-NUM_CNT){1'b0}}, maskQ};
    if (regAddr == STAT_ADDR) rdMux = statusQ;
  end

  always_comb begin
    statSet = '0;
    statSet[NUM_CNT-1:0]           = hitHalf;
    statSet[FULL_OFS +: NUM_CNT]   = hitFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ     <= '0;
      statusQ   <= '0;
      regRdData <= '0;
    end else begin
      if (regWrEn && regAddr == MASK_ADDR) maskQ <= regWrData[NUM_CNT-1:0];
      statusQ <= (rdStat ? '0 : statusQ) | statSet;
      if (regRdEn) regRdData <= rdMux;
    end
  end

  assign irq = |((statusQ[NUM_CNT-1:0] | statusQ[FULL_OFS +: NUM_CNT]) & ~maskQ);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !rdStat |=> (statusQ & $past(statusQ)) == $past(statusQ)); // R11
  AST_HALF_RECORDED: assert property (@(posedge clk) disable iff (!rstN)
    (hitHalf != '0) |=> (statusQ[NUM_CNT-1:0] & $past(hitHalf)) == $past(hitHalf)); // R7
  AST_FULL_RECORDED: assert property (@(posedge clk) disable iff (!rstN)
    (hitFull != '0) |=> (statusQ[FULL_OFS +: NUM_CNT] & $past(hitFull)) == $past(hitFull)); // R8
  AST_MASK_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == MASK_ADDR) |=> regRdData[CNT_W-1:NUM_CNT] == '0); // R12
endmodule

// File: rtl/statsCounterBank.sv
module statsCounterBank
  import statsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txDone,
  input  logic              txRetry,
  input  logic              txGood,
  input  logic              txUnderflow,
  input  logic              txCarrierErr,
  input  logic [AMT_W-1:0]  txBytes,
  input  logic              rxDone,
  input  logic [AMT_W-1:0]  rxBytes,
  input  logic              rxMulticast,
  input  logic              rxCrcErr,
  input  logic              rxLenErr,
  input  logic              rxFifoOvf,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic              irq
);
  strobe_t                       strb;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0]            hitHalf;
  logic [NUM_CNT-1:0]            hitFull;

  statsCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .txDone(txDone), .txRetry(txRetry), .txGood(txGood),
    .txUnderflow(txUnderflow), .txCarrierErr(txCarrierErr), .txBytes(txBytes),
    .rxDone(rxDone), .rxBytes(rxBytes), .rxMulticast(rxMulticast),
    .rxCrcErr(rxCrcErr), .rxLenErr(rxLenErr), .rxFifoOvf(rxFifoOvf),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .cntVal(cntVal), .hitHalf(hitHalf), .hitFull(hitFull),
    .strb(strb), .regRdData(regRdData), .irq(irq)
  );

  statsDatapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cntVal(cntVal), .hitHalf(hitHalf), .hitFull(hitFull)
  );
endmodule

// File: tb/statsCounterBank_tb_top.sv
module statsCounterBank_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit txDone, txRetry, txGood, txUf, txCar;
    int txBytes;
    bit rxDone, rxMc, rxCrc, rxLen, rxOvf;
    int rxBytes;
  } ev_t;

  logic clk = 0, rstN = 0;
  logic txDone = 0, txRetry = 0, txGood = 0, txUnderflow = 0, txCarrierErr = 0;
  logic [15:0] txBytes = 0, rxBytes = 0;
  logic rxDone = 0, rxMulticast = 0, rxCrcErr = 0, rxLenErr = 0, rxFifoOvf = 0;
  logic [3:0] regAddr = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic irq;

  logic [31:0] expCnt [12];
  logic [31:0] expStat;
  logic [11:0] expMask;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  statsCounterBank dut_i (
    .clk(clk), .rstN(rstN),
    .txDone(txDone), .txRetry(txRetry), .txGood(txGood),
    .txUnderflow(txUnderflow), .txCarrierErr(txCarrierErr), .txBytes(txBytes),
    .rxDone(rxDone), .rxBytes(rxBytes), .rxMulticast(rxMulticast),
    .rxCrcErr(rxCrcErr), .rxLenErr(rxLenErr), .rxFifoOvf(rxFifoOvf),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(int a);
    if (a < 12) return expCnt[a];
    if (a == 12) return {20'b0, expMask};
    if (a == 13) return expStat;
    return 32'h0;
  endfunction

  function automatic logic expIrq();
    return |((expStat[11:0] | expStat[27:16]) & ~expMask);
  endfunction

  function automatic ev_t noEv();
    ev_t e = '{default: 0};
    return e;
  endfunction

  function automatic ev_t txEv(bit retry, bit good, bit uf, bit car, int bytes);
    ev_t e = noEv();
    e.txDone = 1; e.txRetry = retry; e.txGood = good; e.txUf = uf; e.txCar = car;
    e.txBytes = bytes;
    return e;
  endfunction

  function automatic ev_t rxEv(bit mc, bit crc, bit len, bit ovf, int bytes);
    ev_t e = noEv();
    e.rxDone = 1; e.rxMc = mc; e.rxCrc = crc; e.rxLen = len; e.rxOvf = ovf;
    e.rxBytes = bytes;
    return e;
  endfunction

  // one clock cycle: drive at negedge, model the edge, check a quarter period after it
  task automatic cyc(ev_t e, bit wr, bit rd, int addr, logic [31:0] data, string req);
    bit en [12];
    int amt [12];
    logic [31:0] hits, rdExp;
    logic [32:0] s;
    bit txc;
    @(negedge clk);
    txDone = e.txDone; txRetry = e.txRetry; txGood = e.txGood;
    txUnderflow = e.txUf; txCarrierErr = e.txCar; txBytes = 16'(e.txBytes);
    rxDone = e.rxDone; rxMulticast = e.rxMc; rxCrcErr = e.rxCrc;
    rxLenErr = e.rxLen; rxFifoOvf = e.rxOvf; rxBytes = 16'(e.rxBytes);
    regWrEn = wr; regRdEn = rd; regAddr = 4'(addr); regWrData = data;
    txc = e.txDone && !e.txRetry;
    en[0] = txc;             amt[0] = e.txBytes & 16'hFFFF;
    en[1] = txc;             amt[1] = 1;
    en[2] = txc && e.txGood; amt[2] = e.txBytes & 16'hFFFF;
    en[3] = txc && e.txGood; amt[3] = 1;
    en[4] = txc && e.txUf;   amt[4] = 1;
    en[5] = txc && e.txCar;  amt[5] = 1;
    en[6] = e.rxDone;        amt[6] = 1;
    en[7] = e.rxDone;        amt[7] = e.rxBytes & 16'hFFFF;
    en[8] = e.rxDone && e.rxMc;  amt[8] = 1;
    en[9] = e.rxDone && e.rxCrc; amt[9] = 1;
    en[10] = e.rxDone && e.rxLen; amt[10] = 1;
    en[11] = e.rxDone && e.rxOvf; amt[11] = 1;
    rdExp = expRead(addr);
    hits = 0;
    for (int i = 0; i < 12; i++) begin
      if (en[i] && !(wr && addr == i)) begin
        s = {1'b0, expCnt[i]} + 33'(amt[i]);
        if (expCnt[i] < 32'h8000_0000 && s >= 33'h0_8000_0000) hits[i] = 1'b1;
        if (expCnt[i] != 32'hFFFF_FFFF && s >= 33'h0_FFFF_FFFF) hits[16+i] = 1'b1;
        expCnt[i] = s[31:0];
      end
    end
    if (wr) begin
      if (addr < 12) expCnt[addr] = data;
      else if (addr == 12) expMask = data[11:0];
    end
    expStat = ((rd && addr == 13) ? 32'h0 : expStat) | hits;
    @(posedge clk);
    #(CLK_PERIOD/4);
    txDone = 0; rxDone = 0; regWrEn = 0; regRdEn = 0;
    if (rd) check({req, " read"}, regRdData, rdExp);
    check({"R13 irq/", req}, {31'b0, irq}, {31'b0, expIrq()});
  endtask

  task automatic rd(int a, string req);
    cyc(noEv(), 0, 1, a, 32'h0, req);
  endtask

  task automatic wr(int a, logic [31:0] d, string req);
    cyc(noEv(), 1, 0, a, d, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 12; i++) expCnt[i] = 0;
    expStat = 0; expMask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1 check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R1 / R2: reset values and empty addresses
    for (int a = 0; a < 14; a++) rd(a, "R1");
    rd(14, "R2"); rd(15, "R2");

    // R3 / R4 / R5: transmit counting, retry ignored
    cyc(txEv(0, 1, 0, 0, 100), 0, 0, 0, 0, "R4");
    cyc(txEv(1, 1, 1, 1, 500), 0, 0, 0, 0, "R3");
    for (int a = 0; a < 6; a++) rd(a, "R3 retry ignored");
    cyc(txEv(0, 0, 1, 1, 60), 0, 0, 0, 0, "R5");
    for (int a = 0; a < 6; a++) rd(a, "R5");
    rd(2, "R4"); rd(3, "R4");

    // R6: receive counting
    cyc(rxEv(1, 1, 0, 1, 64), 0, 0, 0, 0, "R6");
    cyc(rxEv(0, 0, 1, 0, 1500), 0, 0, 0, 0, "R6");
    for (int a = 6; a < 12; a++) rd(a, "R6");

    // R7: half scale crossed by one octet add
    wr(0, 32'h7FFF_FF00, "R7");
    cyc(txEv(0, 0, 0, 0, 16'h0200), 0, 0, 0, 0, "R7");
    check("R7 irq up", {31'b0, irq}, 32'h1);
    rd(13, "R7 status");
    rd(0, "R7 value");
    rd(13, "R11 cleared");

    // R8 / R10: full scale, then wrap
    wr(1, 32'hFFFF_FFFE, "R8");
    cyc(txEv(0, 0, 0, 0, 0), 0, 0, 0, 0, "R8");
    rd(1, "R8 value");
    cyc(txEv(0, 0, 0, 0, 0), 0, 0, 0, 0, "R10");
    rd(1, "R10 wrapped");
    rd(13, "R8 status");
    wr(7, 32'hFFFF_FFF0, "R10");
    cyc(rxEv(0, 0, 0, 0, 16'h0020), 0, 0, 0, 0, "R8");
    rd(7, "R10 octet wrap");
    rd(13, "R8 octet cross");

    // R12: mask suppresses both events but keeps status
    wr(12, 32'hFFFF_F040, "R12");
    rd(12, "R12 reserved zero");
    wr(6, 32'h7FFF_FFFF, "R12");
    cyc(rxEv(0, 0, 0, 0, 0), 0, 0, 0, 0, "R12");
    check("R12 irq masked", {31'b0, irq}, 32'h0);
    wr(6, 32'hFFFF_FFFE, "R12");
    cyc(rxEv(0, 0, 0, 0, 0), 0, 0, 0, 0, "R12");
    check("R12 irq masked full", {31'b0, irq}, 32'h0);
    wr(12, 32'h0, "R12");
    check("R12 irq unmasked", {31'b0, irq}, 32'h1);
    rd(13, "R12 status kept");

    // R9: write wins over same-cycle increment; status and spare writes ignored
    cyc(txEv(0, 1, 0, 0, 10), 1, 0, 3, 32'h7FFF_FFFF, "R9");
    rd(3, "R9 write wins");
    wr(13, 32'hFFFF_FFFF, "R9"); rd(13, "R9 status write ignored");
    wr(14, 32'h1234_5678, "R9"); rd(14, "R9 spare addr");

    // R11: event in same cycle as status read stays pending
    wr(9, 32'h7FFF_FFFF, "R11");
    cyc(rxEv(0, 1, 0, 0, 0), 0, 1, 13, 0, "R11");
    check("R11 irq held", {31'b0, irq}, 32'h1);
    rd(13, "R11 pending bit");

    // random phase
    for (int it = 0; it < 600; it++) begin
      ev_t e = noEv();
      int op = $urandom_range(0, 15);
      int a = $urandom_range(0, 15);
      logic [31:0] d = $urandom();
      if ($urandom_range(0, 1)) e = txEv($urandom_range(0, 3) == 0, $urandom_range(0, 1),
                                          $urandom_range(0, 1), $urandom_range(0, 1),
                                          $urandom_range(0, 16'hFFFF));
      if ($urandom_range(0, 1)) begin
        ev_t r = rxEv($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                      $urandom_range(0, 1), $urandom_range(0, 16'hFFFF));
        e.rxDone = r.rxDone; e.rxMc = r.rxMc; e.rxCrc = r.rxCrc;
        e.rxLen = r.rxLen; e.rxOvf = r.rxOvf; e.rxBytes = r.rxBytes;
      end
      if (op < 2) begin
        if (a < 12) d = ($urandom_range(0, 1) ? 32'h7FFF_0000 : 32'hFFFF_0000) | 32'($urandom_range(0, 16'hFFFF));
        cyc(e, 1, 0, a, d, "R9 random");
      end else if (op < 7) begin
        cyc(e, 0, 1, a, 0, "R2 random");
      end else begin
        cyc(e, 0, 0, 0, 0, "R7 R8 random");
      end
    end
    for (int a = 0; a < 16; a++) rd(a, "R2 final");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule